// File: doc/BRIEF.md
# ADC Output Word Formatter

This block sits on the digital output path of a multi-channel 13-bit pipelined converter. Each channel delivers a raw offset-binary sample with a valid strobe. The block turns that sample into the word presented at the pins, together with an out-of-range flag. All channels share one numeric-format select and one output-mode select. Each channel is processed on its own lane in the same cycle, and a single register stage sits between input and output.

Three output modes exist. The full mode presents all 13 bits. The trimmed mode drops the least significant bit and presents a 12-bit word. The half-scale mode models a 1 Vpp input range. It presents the low 12 bits of the two's-complement word, which wraps once the smaller range is exceeded. The block judges over-range and under-range from the two top bits and clamps the presented word to the signed extreme. Half-scale mode supports only two's complement. If offset binary is requested in that mode, the block still produces two's complement and raises a configuration-error output.

Top module: `adc_word_formatter`

## Requirements
- R1: Every output (valid, word, flag, configuration error) is registered. out_valid[c] equals in_valid[c] from one clock earlier. During reset all outputs are 0.
- R2: fmt_twos=0 selects offset binary and fmt_twos=1 selects two's complement. In every mode the two's-complement form is the offset-binary form with the top presented bit inverted. Midscale raw 4096 appears as 0x1000 in offset binary and as 0x0000 in two's complement (full mode).
- R3: out_mode=0 (full) presents raw bits 12:0 on out_word[12:0]. out_mode=3 behaves exactly like out_mode=0.
- R4: In full mode the flag is 1 exactly when the raw sample is all ones (over-range) or all zeros (under-range). The word is then all ones or all zeros in the offset-binary sense, before the format is applied.
- R5: out_mode=1 (trimmed) presents raw bits 12:1 on out_word[11:0], with out_word[12]=0. The flag is 1 only when all 13 raw bits are equal, so 0x1FFE gives 0xFFF with the flag at 0.
- R6: out_mode=2 (half-scale) computes t = raw with bit 12 inverted and presents t[11:0] on out_word[11:0], with out_word[12]=0, regardless of fmt_twos.
- R7: In half-scale mode, t[12]=0 with t[11]=1 is over-range, giving word 0x7FF and flag 1. t[12]=1 with t[11]=0 is under-range, giving word 0x800 and flag 1. Any other t leaves the flag at 0.
- R8: config_error is 1 in the cycle after an edge at which out_mode=2 and fmt_twos=0, and 0 otherwise.
- R9: When in_valid[c]=0, out_word and out_range of lane c keep their previous values.
- R10: Lanes are independent. Each lane's word and flag depend only on that lane's own sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fmt_twos | input | 1 | 0 offset binary, 1 two's complement |
| out_mode | input | 2 | 0 full, 1 trimmed, 2 half-scale, 3 as full |
| in_valid | input | NUM_CH | Per-lane sample strobe |
| in_code | input | NUM_CH*SAMPLE_W | Raw offset-binary samples, lane c at bits c*SAMPLE_W+: SAMPLE_W |
| out_valid | output | NUM_CH | Registered strobe |
| out_word | output | NUM_CH*SAMPLE_W | Presented words, same packing as in_code |
| out_range | output | NUM_CH | Out-of-range flag per lane |
| config_error | output | 1 | Half-scale mode requested with offset binary |

## Verification
The bench builds the block with its defaults, SAMPLE_W=13 and NUM_CH=2. With these values the exact code points that the requirements name can be reached. These include midscale 4096, the 0x1FFE boundary of the trimmed mode, and the wrap points 6143/6144 and 2047/2048 of the half-scale window. Two lanes are enough to drive over-range on one lane and under-range on the other in the same cycle, which shows that the lanes are independent. They also allow one lane to be held while the other keeps updating.

// File: rtl/fmt_pkg.sv
package fmt_pkg;

   typedef enum logic [1:0] {
      MODE_FULL = 2'd0,
      MODE_TRIM = 2'd1,
      MODE_HALF = 2'd2,
      MODE_ALT  = 2'd3
   } out_mode_e;

   // Collapse the spare encoding onto the full mode.
   function automatic out_mode_e norm_mode(input logic [1:0] m);
      out_mode_e r;
      case (m)
         2'd1:    r = MODE_TRIM;
         2'd2:    r = MODE_HALF;
         default: r = MODE_FULL;
      endcase
      return r;
   endfunction

endpackage

// File: rtl/fmt_range_detect.sv
module fmt_range_detect
   import fmt_pkg::*;
#(
   parameter int W = 13
) (
   input  logic [W-1:0] raw,
   input  out_mode_e    mode,
   output logic         over,
   output logic         under
);
   localparam logic [W-1:0] MSB_MASK = {1'b1, {(W-1){1'b0}}};

   logic [W-1:0] signed_view;
   logic         all_one;
   logic         all_zero;

   assign signed_view = raw ^ MSB_MASK;
   assign all_one     = &raw;
   assign all_zero    = ~|raw;

   always_comb begin
      over  = 1'b0;
      under = 1'b0;
      case (mode)
         MODE_HALF: begin
            // Wrapped window: top two bits disagree means outside the half range.
            over  = ~signed_view[W-1] &  signed_view[W-2];
            under =  signed_view[W-1] & ~signed_view[W-2];
         end
         default: begin
            // Full and trimmed views both require every raw bit equal.
            over  = all_one;
            under = all_zero;
         end
      endcase
   end

endmodule

// File: rtl/fmt_code_shaper.sv
module fmt_code_shaper
   import fmt_pkg::*;
#(
   parameter int W = 13
) (
   input  logic [W-1:0] raw,
   input  out_mode_e    mode,
   input  logic         twos,
   input  logic         over,
   input  logic         under,
   output logic [W-1:0] word
);
   localparam int NW = W - 1;
   localparam logic [W-1:0]  MSB_MASK  = {1'b1, {(W-1){1'b0}}};
   localparam logic [NW-1:0] NMSB_MASK = {1'b1, {(NW-1){1'b0}}};
   localparam logic [NW-1:0] SMAX      = {1'b0, {(NW-1){1'b1}}};
   localparam logic [NW-1:0] SMIN      = {1'b1, {(NW-1){1'b0}}};

   logic [W-1:0]  full_word;
   logic [NW-1:0] trim_word;
   logic [NW-1:0] half_word;
   logic [W-1:0]  signed_view;

   assign signed_view = raw ^ MSB_MASK;

   always_comb begin
      if (over)
         full_word = {W{1'b1}};
      else if (under)
         full_word = {W{1'b0}};
      else
         full_word = raw;
      if (twos)
         full_word = full_word ^ MSB_MASK;
   end

   always_comb begin
      if (over)
         trim_word = {NW{1'b1}};
      else if (under)
         trim_word = {NW{1'b0}};
      else
         trim_word = raw[W-1:1];
      if (twos)
         trim_word = trim_word ^ NMSB_MASK;
   end

   always_comb begin
      if (over)
         half_word = SMAX;
      else if (under)
         half_word = SMIN;
      else
         half_word = signed_view[NW-1:0];
   end

   always_comb begin
      case (mode)
         MODE_TRIM: word = {1'b0, trim_word};
         MODE_HALF: word = {1'b0, half_word};
         default:   word = full_word;
      endcase
   end

endmodule

// File: rtl/fmt_lane.sv
module fmt_lane
   import fmt_pkg::*;
#(
   parameter int W = 13
) (
   input  logic         clk,
   input  logic         rst_n,
   input  out_mode_e    mode,
   input  logic         twos,
   input  logic         in_valid,
   input  logic [W-1:0] in_code,
   output logic         out_valid,
   output logic [W-1:0] out_word,
   output logic         out_range
);
   logic         over;
   logic         under;
   logic [W-1:0] shaped;

   fmt_range_detect #(.W(W)) u_det (
      .raw   (in_code),
      .mode  (mode),
      .over  (over),
      .under (under)
   );

   fmt_code_shaper #(.W(W)) u_shape (
      .raw   (in_code),
      .mode  (mode),
      .twos  (twos),
      .over  (over),
      .under (under),
      .word  (shaped)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_word  <= '0;
         out_range <= 1'b0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            out_word  <= shaped;
            out_range <= over | under;
         end
      end
   end

endmodule

// File: rtl/adc_word_formatter.sv
module adc_word_formatter
   import fmt_pkg::*;
#(
   parameter int SAMPLE_W = 13,
   parameter int NUM_CH   = 2
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       fmt_twos,
   input  logic [1:0]                 out_mode,
   input  logic [NUM_CH-1:0]          in_valid,
   input  logic [NUM_CH*SAMPLE_W-1:0] in_code,
   output logic [NUM_CH-1:0]          out_valid,
   output logic [NUM_CH*SAMPLE_W-1:0] out_word,
   output logic [NUM_CH-1:0]          out_range,
   output logic                       config_error
);
   initial begin
      if (SAMPLE_W < 4)
         $error("adc_word_formatter: SAMPLE_W must be at least 4");
      if (NUM_CH < 1)
         $error("adc_word_formatter: NUM_CH must be at least 1");
   end

   out_mode_e mode_n;
   logic      half_sel;
   logic      twos_eff;

   assign mode_n   = norm_mode(out_mode);
   assign half_sel = (mode_n == MODE_HALF);
   assign twos_eff = fmt_twos | half_sel;

   always_ff @(posedge clk) begin
      if (!rst_n)
         config_error <= 1'b0;
      else
         config_error <= half_sel & ~fmt_twos;
   end

   for (genvar c = 0; c < NUM_CH; c++) begin : g_lane
      fmt_lane #(.W(SAMPLE_W)) u_lane (
         .clk       (clk),
         .rst_n     (rst_n),
         .mode      (mode_n),
         .twos      (twos_eff),
         .in_valid  (in_valid[c]),
         .in_code   (in_code[c*SAMPLE_W +: SAMPLE_W]),
         .out_valid (out_valid[c]),
         .out_word  (out_word[c*SAMPLE_W +: SAMPLE_W]),
         .out_range (out_range[c])
      );
   end

endmodule

// File: rtl/fmt_checks.sv
module fmt_checks #(
   parameter int W      = 13,
   parameter int NUM_CH = 2
) (
   input logic                clk,
   input logic                rst_n,
   input logic                fmt_twos,
   input logic [1:0]          out_mode,
   input logic [NUM_CH-1:0]   in_valid,
   input logic [NUM_CH*W-1:0] in_code,
   input logic [NUM_CH-1:0]   out_valid,
   input logic [NUM_CH*W-1:0] out_word,
   input logic [NUM_CH-1:0]   out_range,
   input logic                config_error
);
   localparam int NW = W - 1;
   localparam logic [NW-1:0] SMAX = {1'b0, {(NW-1){1'b1}}};
   localparam logic [NW-1:0] SMIN = {1'b1, {(NW-1){1'b0}}};

   a_r8_cfg_err: assert property (@(posedge clk) disable iff (!rst_n)
      config_error == $past(out_mode == 2'd2 && !fmt_twos));

   for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
      a_r1_valid_latency: assert property (@(posedge clk) disable iff (!rst_n)
         out_valid[c] == $past(in_valid[c]));

      a_r4_full_flag: assert property (@(posedge clk) disable iff (!rst_n)
         (out_valid[c] && ($past(out_mode) == 2'd0 || $past(out_mode) == 2'd3))
         |-> out_range[c] == ((&$past(in_code[c*W +: W])) || !(|$past(in_code[c*W +: W]))));

      a_r7_half_clamp: assert property (@(posedge clk) disable iff (!rst_n)
         (out_valid[c] && out_range[c] && $past(out_mode) == 2'd2)
         |-> (out_word[c*W +: NW] == SMAX || out_word[c*W +: NW] == SMIN));

      a_r6_half_top_zero: assert property (@(posedge clk) disable iff (!rst_n)
         (out_valid[c] && $past(out_mode) != 2'd0 && $past(out_mode) != 2'd3)
         |-> !out_word[c*W + W - 1]);

      a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
         !$past(in_valid[c]) |-> ($stable(out_word[c*W +: W]) && $stable(out_range[c])));
   end

endmodule

bind adc_word_formatter fmt_checks #(.W(SAMPLE_W), .NUM_CH(NUM_CH)) u_fmt_checks (
   .clk          (clk),
   .rst_n        (rst_n),
   .fmt_twos     (fmt_twos),
   .out_mode     (out_mode),
   .in_valid     (in_valid),
   .in_code      (in_code),
   .out_valid    (out_valid),
   .out_word     (out_word),
   .out_range    (out_range),
   .config_error (config_error)
);

// File: tb/tb_adc_word_formatter.sv
`timescale 1ns/1ps
module tb_adc_word_formatter;
   localparam int  W      = 13;
   localparam int  NCH    = 2;
   localparam time CLK_PERIOD = 10ns;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             fmt_twos = 1'b0;
   logic [1:0]       out_mode = 2'd0;
   logic [NCH-1:0]   in_valid = '0;
   logic [NCH*W-1:0] in_code = '0;
   logic [NCH-1:0]   out_valid;
   logic [NCH*W-1:0] out_word;
   logic [NCH-1:0]   out_range;
   logic             config_error;

   int n_tests = 0;
   int n_fail  = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   adc_word_formatter #(.SAMPLE_W(W), .NUM_CH(NCH)) dut (
      .clk(clk), .rst_n(rst_n), .fmt_twos(fmt_twos), .out_mode(out_mode),
      .in_valid(in_valid), .in_code(in_code), .out_valid(out_valid),
      .out_word(out_word), .out_range(out_range), .config_error(config_error)
   );

   task automatic check(input string req, input int got, input int exp);
      n_tests++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s got=0x%0h exp=0x%0h", req, got, exp);
      end
   endtask

   // Apply one sample pair at a falling edge; results sampled at the next falling edge.
   task automatic apply(input logic [1:0] m, input logic tw, input logic [NCH-1:0] v,
                        input logic [W-1:0] c0, input logic [W-1:0] c1);
      @(negedge clk);
      out_mode = m;
      fmt_twos = tw;
      in_valid = v;
      in_code  = {c1, c0};
      @(negedge clk);
   endtask

   task automatic chk_lane(input string req, input int ch, input int exp_word, input int exp_flag);
      check(req, int'(out_word[ch*W +: W]), exp_word);
      check(req, int'(out_range[ch]), exp_flag);
   endtask

   task automatic t_reset;
      check("R1 reset valid", int'(out_valid), 0);
      check("R1 reset word", int'(out_word), 0);
      check("R1 reset flag", int'(out_range), 0);
      check("R1 reset cfg", int'(config_error), 0);
   endtask

   task automatic t_full;
      apply(2'd0, 1'b0, 2'b11, 13'd4096, 13'd1234);
      check("R1 valid latency", int'(out_valid), 3);
      chk_lane("R2 midscale offset", 0, 'h1000, 0);
      chk_lane("R3 full passthrough", 1, 1234, 0);
      apply(2'd0, 1'b1, 2'b11, 13'd4096, 13'd1234);
      chk_lane("R2 midscale twos", 0, 'h0000, 0);
      chk_lane("R2 twos msb flip", 1, 1234 ^ 'h1000, 0);
      apply(2'd3, 1'b0, 2'b11, 13'h1FFF, 13'h0000);
      chk_lane("R4 over full mode3", 0, 'h1FFF, 1);
      chk_lane("R4 under full mode3", 1, 'h0000, 1);
      apply(2'd0, 1'b1, 2'b11, 13'h1FFF, 13'h0001);
      chk_lane("R4 over twos", 0, 'h0FFF, 1);
      chk_lane("R4 near bottom no flag", 1, 'h1001, 0);
   endtask

   task automatic t_trim;
      apply(2'd1, 1'b0, 2'b11, 13'h1FFE, 13'h0001);
      chk_lane("R5 top edge no flag", 0, 'h0FFF, 0);
      chk_lane("R5 bottom edge no flag", 1, 'h0000, 0);
      apply(2'd1, 1'b1, 2'b11, 13'h1FFF, 13'd4097);
      chk_lane("R5 over twos", 0, 'h07FF, 1);
      chk_lane("R5 midscale twos", 1, 'h0000, 0);
      apply(2'd1, 1'b0, 2'b11, 13'h0000, 13'd4097);
      chk_lane("R5 under", 0, 'h0000, 1);
      chk_lane("R5 midscale offset", 1, 'h0800, 0);
   endtask

   task automatic t_half;
      apply(2'd2, 1'b1, 2'b11, 13'd6143, 13'd6144);
      chk_lane("R6 top in range", 0, 'h7FF, 0);
      chk_lane("R7 over wrap", 1, 'h7FF, 1);
      apply(2'd2, 1'b1, 2'b11, 13'd2048, 13'd2047);
      chk_lane("R6 bottom in range", 0, 'h800, 0);
      chk_lane("R7 under wrap", 1, 'h800, 1);
      apply(2'd2, 1'b1, 2'b11, 13'd4096, 13'd4095);
      chk_lane("R6 zero", 0, 'h000, 0);
      chk_lane("R6 minus one", 1, 'hFFF, 0);
      apply(2'd2, 1'b1, 2'b11, 13'h1FFF, 13'h0000);
      chk_lane("R7 extreme over", 0, 'h7FF, 1);
      chk_lane("R7 extreme under", 1, 'h800, 1);
      check("R8 cfg clear twos", int'(config_error), 0);
   endtask

   task automatic t_cfg;
      apply(2'd2, 1'b0, 2'b11, 13'd4100, 13'd6144);
      check("R8 cfg raised", int'(config_error), 1);
      chk_lane("R6 forced twos", 0, 'h004, 0);
      chk_lane("R7 forced twos over", 1, 'h7FF, 1);
      apply(2'd0, 1'b0, 2'b11, 13'd5, 13'd6);
      check("R8 cfg cleared", int'(config_error), 0);
   endtask

   task automatic t_hold_indep;
      apply(2'd0, 1'b0, 2'b11, 13'd100, 13'd200);
      apply(2'd0, 1'b0, 2'b10, 13'h1FFF, 13'd300);
      check("R9 valid low lane0", int'(out_valid[0]), 0);
      chk_lane("R9 lane0 held", 0, 100, 0);
      chk_lane("R10 lane1 updates", 1, 300, 0);
      apply(2'd0, 1'b0, 2'b00, 13'h1FFF, 13'h0000);
      chk_lane("R9 lane0 still held", 0, 100, 0);
      chk_lane("R9 lane1 held", 1, 300, 0);
      apply(2'd0, 1'b0, 2'b11, 13'h1FFF, 13'd777);
      chk_lane("R10 over only lane0", 0, 'h1FFF, 1);
      chk_lane("R10 lane1 unaffected", 1, 777, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      @(negedge clk);
      rst_n = 1'b1;
      t_full();
      t_trim();
      t_half();
      t_cfg();
      t_hold_indep();
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 100000);
      n_tests++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule